// File: doc/BRIEF.md
# Byte-Addressed Register Slave on a Two-Wire Bus

This block is a two-wire serial bus slave that gives an external master byte-wide read and write access to an internal register file. A system clock that runs much faster than the bus clock samples the clock and data lines. The block finds START and STOP conditions on those sampled lines and shifts in the address, pointer and data bytes. It returns the acknowledge bit by pulling the data line low through an open-drain enable.

A transfer opens with a START. The first byte carries a fixed four-bit device-type code, three bits that must match the `strap` pins, and a direction bit. A write transfer then sends a register pointer and any number of data bytes. A read transfer streams bytes from the pointer onward for as long as the master acknowledges each one. Two rules guard the registers. While the write-enable latch is clear, every data byte is refused, except a byte aimed at the register that holds the latch. After an accepted write to any of three special registers, the next data byte in the same transfer is refused.

Top module: `i2c_regslave`

## Requirements
- R1: Before the first START the block never drives the data line. After a START or a STOP it releases the data line on the next cycle. A START is data falling while the clock is high. A STOP is data rising while the clock is high.
- R2: The first byte after a START is acknowledged only when bits [7:4] equal 1010 and bits [3:1] equal `strap[2:0]`. Bit 0 selects the direction (1 = read). On a mismatch the block stays silent until the next START.
- R3: An acknowledge holds `sda_oe` high from the fall of the eighth bus clock to the fall of the ninth. It is released before the next low period ends. `sda_oe` only rises on a bus-clock fall.
- R4: In a write transfer the register-pointer byte (the byte after the address) is always acknowledged.
- R5: The write-enable latch is bit 1 of register 86h. While it is 0, a data byte is refused and leaves the register file unchanged, unless the pointer is 86h. While it is 1, data bytes are acknowledged and stored at the pointer.
- R6: After an accepted data write to 80h, 85h or 86h, the next data byte of the same transfer is refused and not stored.
- R7: The pointer advances by one after each accepted data byte and after each byte sent. Multi-byte writes and reads therefore cover consecutive registers.
- R8: Read bytes are sent MSB first, with each bit driven after a bus-clock fall. After the eighth bit the line is released. A master acknowledge (low) starts the next byte. A master non-acknowledge leaves the line released until a STOP or START.
- R9: While `rst_n` is low, and right after reset, `sda_oe` is 0 and every register reads 00h.
- R10: A repeated START restarts the address phase, keeps the pointer, and clears the lock of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Device address bits compared with address byte bits [3:1] |
| sda_oe | output | 1 | Pull data line low when 1, release when 0 |

## Verification
A table of single-byte write-then-read pairs covers three cases. It writes ordinary registers with the latch set and with it clear, which separates the normal write path from the latch refusal. It writes the latch register itself while the latch is clear, which shows the one exception. It clears the latch and sets it again, which proves the gate follows the register contents and is not a sticky flag. Directed transfers then cover the remaining paths. They send bus traffic with no START, and address bytes with a wrong device code or wrong strap bits. They run multi-byte bursts in both directions to expose pointer stepping. They write a byte after a special register, both in the same transfer and across a repeated START, which separates the lock from the latch. They end a read with a non-acknowledge and keep clocking, which confirms the line stays released.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_HOLD
  } state_t;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } kind_t;

  // address byte upper seven bits against device code and strap pins
  function automatic logic addr_hit(input logic [6:0] upper,
                                    input logic [3:0] dev,
                                    input logic [2:0] pins);
    return upper == {dev, pins};
  endfunction

  // data byte gating: lock refuses, latch opens, one register always open
  function automatic logic data_gate(input logic [7:0] ptr,
                                     input logic [7:0] open_reg,
                                     input logic       wel,
                                     input logic       lock);
    return !lock && (wel || (ptr == open_reg));
  endfunction

  function automatic logic is_lock_reg(input logic [7:0] a,
                                       input logic [7:0] r0,
                                       input logic [7:0] r1,
                                       input logic [7:0] r2);
    return (a == r0) || (a == r1) || (a == r2);
  endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  // idle bus is high, so the chains reset to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter int          ADDR_W  = 8,
  parameter logic [7:0]  WEL_REG = 8'h86,
  parameter int          WEL_BIT = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       wel
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr[ADDR_W-1:0]] <= wdata;
    end
  end

  assign rdata = mem[addr[ADDR_W-1:0]];
  assign wel   = mem[WEL_REG[ADDR_W-1:0]][WEL_BIT];

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [7:0] WEL_REG  = 8'h86,
  parameter logic [7:0] LOCK_A   = 8'h80,
  parameter logic [7:0] LOCK_B   = 8'h85
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda_s,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       start_ev,
  input  logic       stop_ev,
  input  logic [2:0] strap,
  input  logic       wel,
  input  logic [7:0] rdata,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] ptr,
  output logic [7:0] rx_byte,
  output logic       byte_end,
  output kind_t      kind,
  output logic       lock
);

  state_t     state;
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       full;
  logic       rw;
  logic       acked;
  logic       mack;
  logic       ack_now;

  always_comb begin
    unique case (kind)
      K_ADDR:  ack_now = addr_hit(sh[7:1], DEV_TYPE, strap);
      K_PTR:   ack_now = 1'b1;
      default: ack_now = data_gate(ptr, WEL_REG, wel, lock);
    endcase
  end

  assign byte_end = (state == ST_RX) && scl_fall && full;
  assign wr_en    = byte_end && (kind == K_DATA) && ack_now;
  assign rx_byte  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      kind   <= K_ADDR;
      sh     <= '0;
      cnt    <= '0;
      full   <= 1'b0;
      rw     <= 1'b0;
      acked  <= 1'b0;
      mack   <= 1'b0;
      ptr    <= '0;
      lock   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= ST_RX;
      kind   <= K_ADDR;
      cnt    <= '0;
      full   <= 1'b0;
      lock   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_ev) begin
      state  <= ST_IDLE;
      lock   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_RX: begin
          if (scl_rise && !full) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (byte_end) begin
            full   <= 1'b0;
            cnt    <= '0;
            acked  <= ack_now;
            sda_oe <= ack_now;
            state  <= ST_ACK;
            unique case (kind)
              K_ADDR: rw  <= sh[0];
              K_PTR:  ptr <= sh;
              default: begin
                if (ack_now) begin
                  ptr <= ptr + 8'd1;
                  if (is_lock_reg(ptr, LOCK_A, LOCK_B, WEL_REG)) lock <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            if (!acked) begin
              state <= ST_HOLD;
            end else if (kind == K_ADDR && rw) begin
              state  <= ST_TX;
              sh     <= rdata;
              sda_oe <= ~rdata[7];
              ptr    <= ptr + 8'd1;
              cnt    <= '0;
            end else begin
              state <= ST_RX;
              kind  <= (kind == K_ADDR) ? K_PTR : K_DATA;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              state  <= ST_MACK;
              sda_oe <= 1'b0;
              cnt    <= '0;
            end else begin
              sh     <= {sh[6:0], 1'b0};
              sda_oe <= ~sh[6];
              cnt    <= cnt + 3'd1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              state  <= ST_TX;
              sh     <= rdata;
              sda_oe <= ~rdata[7];
              ptr    <= ptr + 8'd1;
              cnt    <= '0;
            end else begin
              state <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
  import i2cs_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter logic [7:0] WEL_REG     = 8'h86,
  parameter int         WEL_BIT     = 1,
  parameter logic [7:0] LOCK_A      = 8'h80,
  parameter logic [7:0] LOCK_B      = 8'h85
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap,
  output logic       sda_oe
);

  // named internal events, visible to the bound checker
  logic       sda_s;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_ev;
  logic       stop_ev;
  logic       wel;
  logic       wr_en;
  logic [7:0] ptr;
  logic [7:0] rdata;
  logic [7:0] rx_byte;
  logic       byte_end;
  kind_t      kind;
  logic       lock;

  i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2cs_ctrl #(
    .DEV_TYPE (DEV_TYPE),
    .WEL_REG  (WEL_REG),
    .LOCK_A   (LOCK_A),
    .LOCK_B   (LOCK_B)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .strap    (strap),
    .wel      (wel),
    .rdata    (rdata),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .ptr      (ptr),
    .rx_byte  (rx_byte),
    .byte_end (byte_end),
    .kind     (kind),
    .lock     (lock)
  );

  i2cs_regfile #(
    .ADDR_W  (ADDR_W),
    .WEL_REG (WEL_REG),
    .WEL_BIT (WEL_BIT)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .addr  (ptr),
    .wdata (rx_byte),
    .rdata (rdata),
    .wel   (wel)
  );

endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk
  import i2cs_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  parameter logic [7:0] WEL_REG  = 8'h86
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       byte_end,
  input kind_t      kind,
  input logic [7:0] rx_byte,
  input logic [2:0] strap,
  input logic       wr_en,
  input logic [7:0] ptr,
  input logic       wel,
  input logic       lock
);

  // R9
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_release_chk: assert (!sda_oe);
    end
  end

  // R1
  bus_cond_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |=> !sda_oe);

  // R2
  addr_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && kind == K_ADDR && rx_byte[7:1] != {DEV_TYPE, strap}) |=> !sda_oe);

  // R3
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  // R4
  ptr_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && kind == K_PTR) |=> sda_oe);

  // R5
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wel || ptr == WEL_REG));

  // R6
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !lock);

endmodule

bind i2c_regslave i2cs_chk #(.DEV_TYPE(DEV_TYPE), .WEL_REG(WEL_REG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .byte_end (byte_end),
  .kind     (kind),
  .rx_byte  (rx_byte),
  .strap    (strap),
  .wr_en    (wr_en),
  .ptr      (ptr),
  .wel      (wel),
  .lock     (lock)
);

// File: tb/test_i2c_regslave.sv
module test_i2c_regslave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int WDOG       = 150000;

  // {pointer, data, expected ack, expected readback}
  localparam logic [24:0] VEC [8] = '{
    {8'h10, 8'h5A, 1'b0, 8'h00},
    {8'h86, 8'h02, 1'b1, 8'h02},
    {8'h10, 8'h5A, 1'b1, 8'h5A},
    {8'h20, 8'hC3, 1'b1, 8'hC3},
    {8'h80, 8'h11, 1'b1, 8'h11},
    {8'h86, 8'h00, 1'b1, 8'h00},
    {8'h10, 8'hFF, 1'b0, 8'h5A},
    {8'h86, 8'h02, 1'b1, 8'h02}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sda_oe;
  logic       sda_bus;
  int         checks = 0;
  int         errors = 0;
  int         cyc = 0;
  int         last_drive = -1;
  bit         done = 0;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regslave i_i2c_regslave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_m),
    .sda_i  (sda_bus),
    .strap  (strap),
    .sda_oe (sda_oe)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (sda_oe) last_drive <= cyc;
    if (cyc > WDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic clk_bit(input logic b, output logic got);
    sda_m = b; qw(); scl_m = 1'b1; qw(); got = sda_bus; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], g);
    clk_bit(1'b1, g);
    ack = !g;
  endtask

  task automatic rbyte(input logic give_ack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, g);
      d[i] = g;
    end
    clk_bit(!give_ack, g);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic rd);
    return {4'b1010, s, rd};
  endfunction

  task automatic wr1(input logic [7:0] p, input logic [7:0] d, output logic ack);
    logic a0, a1;
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(p, a1);
    wbyte(d, ack);
    bus_stop();
  endtask

  task automatic rd1(input string req, input logic [7:0] p, output logic [7:0] d);
    logic a0, a1, a2;
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(p, a1);
    bus_start();
    wbyte(dev(strap, 1'b1), a2);
    rbyte(1'b0, d);
    bus_stop();
    chk(req, {5'd0, a0, a1, a2}, 8'h07);
  endtask

  initial begin
    logic       a, a0, a1;
    logic [7:0] d;
    int         mark;

    repeat (5) @(negedge clk);
    // R9 reset holds the line released
    chk("R9 oe in reset", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 oe after reset", {7'd0, sda_oe}, 8'h00);

    // R1 traffic without a START is ignored
    mark = cyc;
    scl_m = 1'b0; qw();
    for (int i = 7; i >= 0; i--) clk_bit(dev(strap, 1'b0) >> i, a);
    clk_bit(1'b1, a);
    scl_m = 1'b1; qw();
    bus_stop();
    chk("R1 no drive before START", {7'd0, last_drive >= mark}, 8'h00);
    scl_m = 1'b0; qw();

    // main table: write one byte, read it back
    for (int v = 0; v < 8; v++) begin
      wr1(VEC[v][24:17], VEC[v][16:9], a);
      chk($sformatf("R5 ack of vector %0d", v), {7'd0, a}, {7'd0, VEC[v][8]});
      rd1("R4 read acks", VEC[v][24:17], d);
      chk($sformatf("R5 readback of vector %0d", v), d, VEC[v][7:0]);
    end

    // R9 untouched register still reads its reset value
    rd1("R4 read acks", 8'h55, d);
    chk("R9 untouched reg", d, 8'h00);

    // R2 wrong strap bits and wrong device code
    mark = cyc;
    bus_start();
    wbyte(dev(~strap, 1'b0), a);
    chk("R2 strap mismatch nack", {7'd0, a}, 8'h00);
    wbyte(8'h10, a);
    wbyte(8'h00, a);
    bus_stop();
    chk("R2 silent after mismatch", {7'd0, last_drive >= mark}, 8'h00);
    bus_start();
    wbyte({4'b1011, strap, 1'b0}, a);
    bus_stop();
    chk("R2 device code mismatch nack", {7'd0, a}, 8'h00);
    rd1("R4 read acks", 8'h10, d);
    chk("R2 no write on mismatch", d, 8'h5A);

    // R2 a new strap value moves the address
    strap = 3'b010;
    repeat (4) @(negedge clk);
    rd1("R2 acks with new strap", 8'h20, d);
    chk("R2 data with new strap", d, 8'hC3);

    // R7 burst write and burst read; R3 release after ack
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(8'h30, a1);
    chk("R3 released after ack", {7'd0, sda_oe}, 8'h00);
    chk("R4 pointer acked", {7'd0, a1}, 8'h01);
    for (int k = 1; k <= 3; k++) begin
      wbyte(8'(k), a);
      chk("R7 burst write ack", {7'd0, a}, 8'h01);
    end
    bus_stop();
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(8'h30, a1);
    bus_start();
    wbyte(dev(strap, 1'b1), a);
    for (int k = 1; k <= 3; k++) begin
      rbyte(k != 3, d);
      chk("R7 burst read", d, 8'(k));
    end
    // R8 after master nack the line stays released
    rbyte(1'b0, d);
    chk("R8 released after master nack", d, 8'hFF);
    bus_stop();

    // R6 byte after a special register is refused
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(8'h85, a1);
    wbyte(8'h77, a);
    chk("R6 special write acked", {7'd0, a}, 8'h01);
    wbyte(8'h99, a);
    chk("R6 following byte nacked", {7'd0, a}, 8'h00);
    bus_stop();
    rd1("R4 read acks", 8'h85, d);
    chk("R6 special reg stored", d, 8'h77);
    rd1("R4 read acks", 8'h86, d);
    chk("R6 next reg unchanged", d, 8'h02);

    // R10 repeated START clears the lock
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(8'h80, a1);
    wbyte(8'h12, a);
    bus_start();
    wbyte(dev(strap, 1'b0), a0);
    wbyte(8'h31, a1);
    wbyte(8'h44, a);
    bus_stop();
    chk("R10 write after repeated START acked", {7'd0, a}, 8'h01);
    rd1("R4 read acks", 8'h31, d);
    chk("R10 write after repeated START stored", d, 8'h44);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule